// File: doc/BRIEF.md
# Dual-Rail Address to Single-Rail Memory Bridge

This block lets a four-phase, dual-rail datapath read from an ordinary single-rail memory. Each address bit comes in as a pair of rails. The block collapses the pairs into a plain binary address for the memory. It also watches every pair for a valid codeword, and once the whole address is valid it raises a completion strobe.

The strobe then passes through a matched delay, counted in clock ticks, that is longer than the memory's read latency. When the delayed strobe is high, the single-rail read word is expanded back into dual-rail form on the output. When any address bit goes back to the spacer, the strobe drops at once and the output returns to the spacer. It does not wait for the delay to run out.

The memory is a behavioural read-only model with a parameterised registered read latency. Its contents are computed from the address.

Top module: `dr_mem_bridge`

## Requirements
- R1: An address bit is 1 when its true rail is high and its false rail is low. It is 0 when the true rail is low and the false rail is high. It is the spacer (null) when both rails are low. Both rails high is never driven.
- R2: While at least one address bit is null, the output stays null, even if all the other bits are valid.
- R3: Suppose the address becomes fully valid between two clock edges. The output is then null at every sample before the DELAY_TICKS-th rising edge after that point, and valid after that edge (DELAY_TICKS defaults to 4).
- R4: The valid output word equals the memory contents at the address, which is (29·a + 7) mod 2^DATA_W.
- R5: In a valid output, a data bit of 1 drives only its true rail and a bit of 0 drives only its false rail. While the delayed strobe is low, both rails of every bit are low.
- R6: When any address bit returns to null, the output goes null within the same cycle, with no clock edge needed.
- R7: The valid output holds for as long as the full address is held.
- R8: While rst_n is low, the output is null and the delay count is held at zero. After release, counting for a valid address starts from the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the matched delay and the memory read |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_t | input | ADDR_W | Address true rails |
| addr_f | input | ADDR_W | Address false rails |
| data_t | output | DATA_W | Read data true rails |
| data_f | output | DATA_W | Read data false rails |

## Verification
The assertions assume that the two rails of an address bit are never high together. They also assume that a complete address stays unchanged until at least one of its bits has gone back to null. The random stimulus respects both assumptions. It builds every address phase from a binary value and a validity mask, so each bit is either a proper codeword or the spacer. It changes the address only by removing bits to null, then by clearing the whole word, and it waits a full clock edge before starting the next phase.

// File: rtl/dr_bridge_pkg.sv
package dr_bridge_pkg;

   // Behavioural ROM contents: a linear pattern so every word is distinct
   function automatic logic [31:0] rom_word(input logic [31:0] a);
      return (a * 32'd29) + 32'd7;
   endfunction

endpackage

// File: rtl/dr_to_sr.sv
module dr_to_sr #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rail_t,
   input  logic [WIDTH-1:0] rail_f,
   output logic [WIDTH-1:0] sr_o,
   output logic             complete_o
);
   logic [WIDTH-1:0] bit_ok;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bit_ok[i] = rail_t[i] ^ rail_f[i];
      assign sr_o[i]   = rail_t[i];
   end

   assign complete_o = &bit_ok;

   // R1
   no_illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_t & rail_f) == '0);

endmodule

// File: rtl/strobe_delay.sv
module strobe_delay #(
   parameter int DELAY_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic complete_i,
   output logic strobe_o
);
   localparam int CW = $clog2(DELAY_TICKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(DELAY_TICKS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!complete_i)     cnt_q <= '0;
      else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
   end

   // Drops combinationally with completion: no wait on the way back to null
   assign strobe_o = complete_i && (cnt_q == LIMIT);

   // R3
   strobe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $past(complete_i));

endmodule

// File: rtl/sr_mem.sv
module sr_mem #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int READ_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [31:0]       full_word;
   logic [DATA_W-1:0] word_c;

   always_comb begin
      full_word = dr_bridge_pkg::rom_word(32'(addr_i));
      word_c    = full_word[DATA_W-1:0];
   end

   if (READ_LAT == 0) begin : g_comb
      assign rdata_o = word_c;
   end else begin : g_pipe
      logic [READ_LAT-1:0][DATA_W-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= '0;
         end else begin
            stage_q[0] <= word_c;
            for (int s = 1; s < READ_LAT; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign rdata_o = stage_q[READ_LAT-1];
   end

endmodule

// File: rtl/sr_to_dr.sv
module sr_to_dr #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_i,
   input  logic [WIDTH-1:0] sr_i,
   output logic [WIDTH-1:0] rail_t,
   output logic [WIDTH-1:0] rail_f
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign rail_t[i] = strobe_i &  sr_i[i];
      assign rail_f[i] = strobe_i & ~sr_i[i];
   end

   // R5
   rails_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_t & rail_f) == '0);

   // R5
   rails_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |-> ((rail_t ^ rail_f) == '1));

endmodule

// File: rtl/dr_mem_bridge.sv
module dr_mem_bridge #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int READ_LAT    = 2,
   parameter int DELAY_TICKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_t,
   input  logic [ADDR_W-1:0] addr_f,
   output logic [DATA_W-1:0] data_t,
   output logic [DATA_W-1:0] data_f
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_dw
      $error("DATA_W out of range");
   end
   if (READ_LAT < 0) begin : g_bad_lat
      $error("READ_LAT must not be negative");
   end
   if (DELAY_TICKS < 1 || DELAY_TICKS <= READ_LAT) begin : g_bad_dly
      $error("DELAY_TICKS must exceed READ_LAT");
   end

   logic [ADDR_W-1:0] addr_sr;
   logic              addr_done;
   logic              strobe_dly;
   logic [DATA_W-1:0] rdata;

   dr_to_sr #(.WIDTH(ADDR_W)) u_in_conv (
      .clk(clk), .rst_n(rst_n), .rail_t(addr_t), .rail_f(addr_f),
      .sr_o(addr_sr), .complete_o(addr_done));

   strobe_delay #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
      .clk(clk), .rst_n(rst_n), .complete_i(addr_done), .strobe_o(strobe_dly));

   sr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_mem (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_sr), .rdata_o(rdata));

   sr_to_dr #(.WIDTH(DATA_W)) u_out_conv (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe_dly), .sr_i(rdata),
      .rail_t(data_t), .rail_f(data_f));

   // R2
   null_on_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr_t ^ addr_f) != '1) |-> (data_t == '0 && data_f == '0));

   // R7
   hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(strobe_dly) && $stable(addr_t) && $stable(addr_f)) |-> strobe_dly);

endmodule

// File: tb/dr_mem_bridge_tb_top.sv
`timescale 1ns/100ps
module dr_mem_bridge_tb_top;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int DLY = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr_t = '0;
   logic [AW-1:0] addr_f = '0;
   logic [DW-1:0] data_t;
   logic [DW-1:0] data_f;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dr_mem_bridge #(.ADDR_W(AW), .DATA_W(DW), .READ_LAT(2), .DELAY_TICKS(DLY)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_t(addr_t), .addr_f(addr_f),
      .data_t(data_t), .data_f(data_f));

   function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
      int unsigned v;
      v = (int'(a) * 29 + 7) % 256;
      return v[DW-1:0];
   endfunction

   task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] mask);
      addr_t = a & mask;
      addr_f = ~a & mask;
   endtask

   task automatic check(input string req, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_null(input string req);
      check(req, {data_t, data_f}, '0);
   endtask

   task automatic check_valid(input string req, input logic [AW-1:0] a);
      check(req, {data_t, data_f}, {exp_word(a), ~exp_word(a)});
   endtask

   task automatic run_phase(input logic [AW-1:0] a, input int hold, input bit drop_all);
      logic [AW-1:0] m;
      drive(a, '1);
      for (int k = 1; k < DLY; k++) begin
         @(negedge clk);
         check_null("R3 early");
      end
      @(negedge clk);
      check_valid("R1 R3 R4 R5 valid", a);
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check_valid("R7 hold", a);
      end
      m = drop_all ? '0 : ~(AW'(1) << ($urandom % AW));
      drive(a, m);
      #1;
      check_null("R6 immediate null");
      @(negedge clk);
      drive('0, '0);
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4242));
      // R8: reset holds output null even with a full address
      drive(6'h15, '1);
      repeat (3) @(negedge clk);
      check_null("R8 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_null("R8 after release");
      for (int k = 2; k < DLY; k++) @(negedge clk);
      @(negedge clk);
      check_valid("R8 R4 after release", 6'h15);
      drive('0, '0);
      #1;
      check_null("R6 full null");
      @(negedge clk);
      @(negedge clk);

      // directed corners: extreme addresses
      run_phase('0, 1, 1'b1);
      run_phase('1, 2, 1'b0);

      // R2: all bits valid except one, held several edges
      drive(6'h2a, 6'h3e);
      repeat (DLY + 2) @(negedge clk);
      check_null("R2 one bit null");
      run_phase(6'h2a, 0, 1'b0);

      // random phases
      for (int t = 0; t < 40; t++) begin
         logic [AW-1:0] a;
         logic [AW-1:0] m;
         a = AW'($urandom);
         m = AW'($urandom) & ~(AW'(1) << ($urandom % AW));
         drive(a, m);
         @(negedge clk);
         check_null("R2 partial");
         @(negedge clk);
         check_null("R2 partial");
         run_phase(a, $urandom % 4, $urandom % 2 == 0);
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule